// File: doc/BRIEF.md
# USB Endpoint FIFO Event Flags

This block keeps the sticky interrupt flags for a set of USB endpoints, each with two FIFO buffers (A and B). For every buffer it latches a "full" event and an "empty" event from single-cycle pulses raised by the FIFO control logic. Which pulse may raise a flag depends on the endpoint's direction. On a transmitting endpoint, "full" means the CPU has filled the buffer and "empty" means the buffer has drained onto the bus. On a receiving endpoint, "full" means the USB controller has filled the buffer and "empty" means the CPU has read it out.

The flags record events, not FIFO levels. Once set, a flag stays set until software clears it by writing 0 to its bit through a small register port. Writing 1 leaves the bit alone. The block ORs all flags into one interrupt request. It also raises a wake request, but only while the processor is in the light idle mode.

Top module: `usbev_flags`

## Requirements
- R1: After reset every flag is 0, both registers read 0x00, and `irq_o` and `wake_o` are 0.
- R2: Register layout, MSB first. Register 0 bits 7..4 hold endpoint 1 as full A, empty A, full B, empty B. Bits 3..0 hold endpoint 2 in the same order. Register 1 bits 7..4 hold endpoint 3. Event input bit index is endpoint*2+buffer, with endpoint 1 as index 0 and buffer A as 0.
- R3: With `ep_tx_i` = 1 (transmit), `cpu_full_i` sets the full flag and `tx_empty_i` sets the empty flag, visible after the next rising edge. `usb_full_i` and `cpu_empty_i` have no effect.
- R4: With `ep_tx_i` = 0 (receive), `usb_full_i` sets the full flag and `cpu_empty_i` sets the empty flag. `cpu_full_i` and `tx_empty_i` have no effect.
- R5: A set flag stays set with no further events until software clears it.
- R6: A register write clears, on that edge, exactly those flags of the addressed register whose written bit is 0.
- R7: Writing 1 to a flag bit leaves it unchanged.
- R8: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Register 1 bits 3..0 always read 0 and are unaffected by writes.
- R10: `irq_o` is 1 exactly when at least one flag is set.
- R11: `wake_o` is 1 exactly when a flag is set and `pwr_mode_i` = 2'b01 (light idle). It stays 0 in run (00), deep idle (10) and stop (11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_tx_i | input | 3 | Per-endpoint direction, 1 = transmit |
| cpu_full_i | input | 6 | Pulse: CPU has filled the buffer (transmit source) |
| usb_full_i | input | 6 | Pulse: USB controller has filled the buffer (receive source) |
| tx_empty_i | input | 6 | Pulse: buffer drained after transmission (transmit source) |
| cpu_empty_i | input | 6 | Pulse: CPU has read the buffer out (receive source) |
| pwr_mode_i | input | 2 | Power mode: 00 run, 01 light idle, 10 deep idle, 11 stop |
| reg_addr_i | input | 1 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data; 0 bits clear flags |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake request for light idle |

## Verification
The checker assumes that event inputs are synchronous to the bus clock and are sampled once per edge, so a pulse held for one cycle counts as a single event. It also assumes that direction and power mode can change at any edge without glitching within a cycle. The bench changes every input at the falling edge and holds each event high for exactly one cycle. It changes direction only while no event is pending. It also combines a set pulse with a clearing write only where it deliberately tests the same-cycle priority case.

// File: rtl/usbev_pkg.sv
package usbev_pkg;

   // Flag kinds inside one buffer slot
   localparam int KIND_FULL  = 0;
   localparam int KIND_EMPTY = 1;
   localparam int NUM_KINDS  = 2;

   typedef enum logic [1:0] {
      PM_RUN        = 2'b00,
      PM_LIGHT_IDLE = 2'b01,
      PM_DEEP_IDLE  = 2'b10,
      PM_STOP       = 2'b11
   } pwr_mode_e;

   // Flat flag position: endpoint-major, then buffer, then kind
   function automatic int flag_index(input int ep, input int nbuf,
                                     input int bufi, input int kind);
      return (ep * nbuf + bufi) * NUM_KINDS + kind;
   endfunction

   // Register holding flag f (MSB-first packing)
   function automatic int flag_reg(input int f, input int reg_w);
      return f / reg_w;
   endfunction

   // Bit position of flag f inside its register
   function automatic int flag_bit(input int f, input int reg_w);
      return reg_w - 1 - (f % reg_w);
   endfunction

endpackage

// File: rtl/usbev_src_sel.sv
module usbev_src_sel
   import usbev_pkg::*;
#(
   parameter int NUM_BUF = 2,
   localparam int SLOT_W = NUM_BUF * NUM_KINDS
) (
   input  logic               tx_i,
   input  logic [NUM_BUF-1:0] cpu_full_i,
   input  logic [NUM_BUF-1:0] usb_full_i,
   input  logic [NUM_BUF-1:0] tx_empty_i,
   input  logic [NUM_BUF-1:0] cpu_empty_i,
   output logic [SLOT_W-1:0]  set_o
);

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      // Direction selects the only source allowed to raise each flag
      assign set_o[b*NUM_KINDS + KIND_FULL]  = tx_i ? cpu_full_i[b]  : usb_full_i[b];
      assign set_o[b*NUM_KINDS + KIND_EMPTY] = tx_i ? tx_empty_i[b] : cpu_empty_i[b];
   end

endmodule

// File: rtl/usbev_flag_bank.sv
module usbev_flag_bank #(
   parameter int NUM_FLAGS = 12,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic [NUM_FLAGS-1:0] clr_i,
   output logic [NUM_FLAGS-1:0] flag_q
);

   logic [NUM_FLAGS-1:0] flag_d;

   if (SET_WINS) begin : g_set_priority
      // An event arriving with a clear is kept
      assign flag_d = set_i | (flag_q & ~clr_i);
   end else begin : g_clr_priority
      assign flag_d = (set_i | flag_q) & ~clr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

endmodule

// File: rtl/usbev_reg_port.sv
module usbev_reg_port
   import usbev_pkg::*;
#(
   parameter int NUM_FLAGS = 12,
   parameter int REG_W     = 8,
   localparam int NUM_REGS = (NUM_FLAGS + REG_W - 1) / REG_W,
   localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 we_i,
   input  logic [REG_W-1:0]     wdata_i,
   input  logic [NUM_FLAGS-1:0] flags_i,
   output logic [REG_W-1:0]     rdata_o,
   output logic [NUM_FLAGS-1:0] clr_o
);

   logic [NUM_REGS*REG_W-1:0] image;

   // Pack flags MSB-first; unmapped positions stay 0
   always_comb begin
      image = '0;
      for (int f = 0; f < NUM_FLAGS; f++) begin
         image[flag_reg(f, REG_W)*REG_W + flag_bit(f, REG_W)] = flags_i[f];
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (addr_i == ADDR_W'(r)) rdata_o = image[r*REG_W +: REG_W];
      end
   end

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_clr
      localparam int RI = flag_reg(f, REG_W);
      localparam int BI = flag_bit(f, REG_W);
      // Zero clears, one is ignored
      assign clr_o[f] = we_i && (addr_i == ADDR_W'(RI)) && !wdata_i[BI];
   end

endmodule

// File: rtl/usbev_flags.sv
module usbev_flags
   import usbev_pkg::*;
#(
   parameter int NUM_EP   = 3,
   parameter int NUM_BUF  = 2,
   parameter int REG_W    = 8,
   parameter bit SET_WINS = 1'b1,
   localparam int EVT_W     = NUM_EP * NUM_BUF,
   localparam int SLOT_W    = NUM_BUF * NUM_KINDS,
   localparam int NUM_FLAGS = NUM_EP * SLOT_W,
   localparam int NUM_REGS  = (NUM_FLAGS + REG_W - 1) / REG_W,
   localparam int ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] ep_tx_i,
   input  logic [EVT_W-1:0]  cpu_full_i,
   input  logic [EVT_W-1:0]  usb_full_i,
   input  logic [EVT_W-1:0]  tx_empty_i,
   input  logic [EVT_W-1:0]  cpu_empty_i,
   input  logic [1:0]        pwr_mode_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_we_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              irq_o,
   output logic              wake_o
);

   if (NUM_EP < 1) begin : g_bad_ep
      $error("usbev_flags: NUM_EP must be at least 1");
   end
   if (NUM_BUF < 1) begin : g_bad_buf
      $error("usbev_flags: NUM_BUF must be at least 1");
   end
   if (REG_W < NUM_KINDS) begin : g_bad_reg
      $error("usbev_flags: REG_W too small");
   end

   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] clr_vec;
   logic [NUM_FLAGS-1:0] flag_q;

   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      usbev_src_sel #(.NUM_BUF(NUM_BUF)) u_sel (
         .tx_i        (ep_tx_i[e]),
         .cpu_full_i  (cpu_full_i[e*NUM_BUF +: NUM_BUF]),
         .usb_full_i  (usb_full_i[e*NUM_BUF +: NUM_BUF]),
         .tx_empty_i  (tx_empty_i[e*NUM_BUF +: NUM_BUF]),
         .cpu_empty_i (cpu_empty_i[e*NUM_BUF +: NUM_BUF]),
         .set_o       (set_vec[e*SLOT_W +: SLOT_W])
      );
   end

   usbev_reg_port #(.NUM_FLAGS(NUM_FLAGS), .REG_W(REG_W)) u_port (
      .addr_i  (reg_addr_i),
      .we_i    (reg_we_i),
      .wdata_i (reg_wdata_i),
      .flags_i (flag_q),
      .rdata_o (reg_rdata_o),
      .clr_o   (clr_vec)
   );

   usbev_flag_bank #(.NUM_FLAGS(NUM_FLAGS), .SET_WINS(SET_WINS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .flag_q (flag_q)
   );

   assign irq_o  = |flag_q;
   assign wake_o = irq_o && (pwr_mode_e'(pwr_mode_i) == PM_LIGHT_IDLE);

endmodule

// File: rtl/usbev_flags_chk.sv
module usbev_flags_chk
   import usbev_pkg::*;
#(
   parameter int NUM_EP  = 3,
   parameter int NUM_BUF = 2,
   parameter int REG_W   = 8,
   localparam int EVT_W     = NUM_EP * NUM_BUF,
   localparam int NUM_FLAGS = NUM_EP * NUM_BUF * NUM_KINDS,
   localparam int NUM_REGS  = (NUM_FLAGS + REG_W - 1) / REG_W,
   localparam int ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_EP-1:0]    ep_tx,
   input logic [EVT_W-1:0]     cpu_full,
   input logic [EVT_W-1:0]     usb_full,
   input logic [EVT_W-1:0]     tx_empty,
   input logic [EVT_W-1:0]     cpu_empty,
   input logic [1:0]           pwr_mode,
   input logic [ADDR_W-1:0]    addr,
   input logic                 we,
   input logic [REG_W-1:0]     wdata,
   input logic [REG_W-1:0]     rdata,
   input logic [NUM_FLAGS-1:0] flags,
   input logic                 irq,
   input logic                 wake
);

   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
         localparam int I  = e*NUM_BUF + b;
         localparam int FF = flag_index(e, NUM_BUF, b, KIND_FULL);
         localparam int FE = flag_index(e, NUM_BUF, b, KIND_EMPTY);
         localparam int RF = flag_reg(FF, REG_W);
         localparam int BF = flag_bit(FF, REG_W);
         localparam int RE = flag_reg(FE, REG_W);
         localparam int BE = flag_bit(FE, REG_W);

         AST_TX_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ep_tx[e] && cpu_full[I] |=> flags[FF]);                          // R3
         AST_TX_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ep_tx[e] && tx_empty[I] |=> flags[FE]);                          // R3
         AST_RX_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            !ep_tx[e] && usb_full[I] |=> flags[FF]);                         // R4
         AST_RX_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            !ep_tx[e] && cpu_empty[I] |=> flags[FE]);                        // R4
         AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flags[FF] && !we |=> flags[FF]);                                 // R5
         AST_EMPTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flags[FE] && !we |=> flags[FE]);                                 // R5
         AST_FULL_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[FF] && !cpu_full[I] && !usb_full[I] |=> !flags[FF]);      // R3
         AST_EMPTY_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[FE] && !tx_empty[I] && !cpu_empty[I] |=> !flags[FE]);     // R4
         AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            we && addr == ADDR_W'(RF) && !wdata[BF] && !cpu_full[I] && !usb_full[I]
            |=> !flags[FF]);                                                 // R6
         AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            we && addr == ADDR_W'(RE) && !wdata[BE] && !tx_empty[I] && !cpu_empty[I]
            |=> !flags[FE]);                                                 // R6
         AST_FULL_WRITE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            flags[FF] && we && addr == ADDR_W'(RF) && wdata[BF] |=> flags[FF]); // R7
         AST_EMPTY_WRITE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            flags[FE] && we && addr == ADDR_W'(RE) && wdata[BE] |=> flags[FE]); // R7
         AST_FULL_READ_MAP: assert property (@(posedge clk) disable iff (!rst_n)
            addr == ADDR_W'(RF) |-> rdata[BF] == flags[FF]);                 // R2
         AST_EMPTY_READ_MAP: assert property (@(posedge clk) disable iff (!rst_n)
            addr == ADDR_W'(RE) |-> rdata[BE] == flags[FE]);                 // R2
      end
   end

   for (genvar p = NUM_FLAGS; p < NUM_REGS*REG_W; p++) begin : g_unused
      localparam int RU = p / REG_W;
      localparam int BU = REG_W - 1 - (p % REG_W);
      AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         addr == ADDR_W'(RU) |-> !rdata[BU]);                                // R9
   end

   AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (flags != '0));                                                 // R10
   AST_WAKE_ONLY_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_mode != PM_LIGHT_IDLE |-> !wake);                                  // R11
   AST_WAKE_IN_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_mode == PM_LIGHT_IDLE && irq |-> wake);                            // R11

endmodule

bind usbev_flags usbev_flags_chk #(
   .NUM_EP (NUM_EP),
   .NUM_BUF(NUM_BUF),
   .REG_W  (REG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ep_tx     (ep_tx_i),
   .cpu_full  (cpu_full_i),
   .usb_full  (usb_full_i),
   .tx_empty  (tx_empty_i),
   .cpu_empty (cpu_empty_i),
   .pwr_mode  (pwr_mode_i),
   .addr      (reg_addr_i),
   .we        (reg_we_i),
   .wdata     (reg_wdata_i),
   .rdata     (reg_rdata_o),
   .flags     (flag_q),
   .irq       (irq_o),
   .wake      (wake_o)
);

// File: tb/sim_usbev_flags.sv
module sim_usbev_flags;
   localparam int CLK_PERIOD = 10;
   localparam int NEP  = 3;
   localparam int NB   = 2;
   localparam int NF   = NEP * NB * 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ep_tx = '0;
   logic [5:0] cpu_full = '0, usb_full = '0, tx_empty = '0, cpu_empty = '0;
   logic [1:0] pwr_mode = 2'b00;
   logic       addr = 1'b0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, wake;

   int checks = 0;
   int errors = 0;
   logic [NF-1:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbev_flags u0 (
      .clk(clk), .rst_n(rst_n), .ep_tx_i(ep_tx),
      .cpu_full_i(cpu_full), .usb_full_i(usb_full),
      .tx_empty_i(tx_empty), .cpu_empty_i(cpu_empty),
      .pwr_mode_i(pwr_mode), .reg_addr_i(addr), .reg_we_i(we),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
   );

   // Expected register image from the model (R2 layout)
   function automatic logic [7:0] exp_reg(input int a);
      logic [7:0] v = '0;
      for (int f = 0; f < NF; f++)
         if (f / 8 == a) v[7 - f % 8] = model[f];
      return v;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_all(input string req);
      for (int a = 0; a < 2; a++) begin
         addr = a[0];
         #1;
         checks++;
         if (rdata !== exp_reg(a)) begin
            errors++;
            $display("FAIL %s reg%0d actual %02h expected %02h", req, a, rdata, exp_reg(a));
         end
      end
      checks++;
      if (irq !== (model != '0)) begin
         errors++;
         $display("FAIL R10 (%s) irq actual %0b expected %0b", req, irq, model != '0);
      end
      checks++;
      if (wake !== ((model != '0) && pwr_mode == 2'b01)) begin
         errors++;
         $display("FAIL R11 (%s) wake actual %0b expected %0b", req, wake,
                  (model != '0) && pwr_mode == 2'b01);
      end
   endtask

   // Raise source src (0 cpu_full,1 usb_full,2 tx_empty,3 cpu_empty) for one cycle
   task automatic drive_src(input int src, input int e, input int b);
      case (src)
         0: cpu_full[e*2+b]  = 1'b1;
         1: usb_full[e*2+b]  = 1'b1;
         2: tx_empty[e*2+b]  = 1'b1;
         default: cpu_empty[e*2+b] = 1'b1;
      endcase
   endtask

   function automatic void model_src(input int src, input int e, input int b);
      int f = (e*2 + b)*2 + ((src >= 2) ? 1 : 0);
      if ((src == 0 || src == 2) && ep_tx[e])  model[f] = 1'b1;
      if ((src == 1 || src == 3) && !ep_tx[e]) model[f] = 1'b1;
   endfunction

   function automatic void model_write(input int a, input logic [7:0] d);
      for (int f = 0; f < NF; f++)
         if (f / 8 == a && !d[7 - f % 8]) model[f] = 1'b0;
   endfunction

   task automatic release_all();
      cpu_full = '0; usb_full = '0; tx_empty = '0; cpu_empty = '0; we = 1'b0;
   endtask

   task automatic reg_write(input int a, input logic [7:0] d);
      addr = a[0]; wdata = d; we = 1'b1;
      model_write(a, d);
      step();
      we = 1'b0;
   endtask

   task automatic set_all();
      ep_tx = 3'b111;
      cpu_full = '1; tx_empty = '1;
      model = '1;
      step();
      release_all();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      step();
      check_all("R1");

      // R3 / R4: every endpoint, direction, buffer and source
      for (int e = 0; e < NEP; e++)
         for (int d = 0; d < 2; d++)
            for (int b = 0; b < NB; b++)
               for (int s = 0; s < 4; s++) begin
                  reg_write(0, 8'h00);
                  reg_write(1, 8'h00);
                  ep_tx[e] = d[0];
                  drive_src(s, e, b);
                  model_src(s, e, b);
                  step();
                  release_all();
                  check_all(d ? "R3" : "R4");
               end

      // R5: flags hold over idle cycles and direction changes
      reg_write(0, 8'h00);
      reg_write(1, 8'h00);
      ep_tx = 3'b101;
      drive_src(0, 0, 1); model_src(0, 0, 1);
      drive_src(3, 1, 0); model_src(3, 1, 0);
      drive_src(2, 2, 0); model_src(2, 2, 0);
      step();
      release_all();
      for (int i = 0; i < 6; i++) step();
      ep_tx = 3'b010;
      step();
      check_all("R5");

      // R6 / R7: clear each flag alone, then write ones
      for (int f = 0; f < NF; f++) begin
         set_all();
         begin
            logic [7:0] d = 8'hFF;
            d[7 - f % 8] = 1'b0;
            reg_write(f / 8, d);
         end
         check_all("R6");
         reg_write(f / 8, 8'hFF);
         check_all("R7");
      end

      // R6: whole register write of zero leaves the other register intact
      set_all();
      reg_write(0, 8'h00);
      check_all("R6");

      // R8: set and clear in the same cycle
      for (int e = 0; e < NEP; e++) begin
         reg_write(0, 8'h00);
         reg_write(1, 8'h00);
         ep_tx = 3'b000;
         drive_src(1, e, 1);
         addr = (e >= 2); wdata = 8'h00; we = 1'b1;
         model_write(e >= 2 ? 1 : 0, 8'h00);
         model_src(1, e, 1);
         step();
         release_all();
         check_all("R8");
      end

      // R9: unused low bits of register 1
      set_all();
      reg_write(1, 8'hF0);
      check_all("R9");
      reg_write(1, 8'h0F);
      check_all("R9");
      reg_write(1, 8'h0F);
      check_all("R9");

      // R10 / R11: every power mode with and without flags
      for (int m = 0; m < 4; m++) begin
         pwr_mode = m[1:0];
         reg_write(0, 8'h00);
         reg_write(1, 8'h00);
         check_all("R11");
         ep_tx = 3'b100;
         drive_src(2, 2, 1); model_src(2, 2, 1);
         step();
         release_all();
         check_all("R11");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule